// File: doc/BRIEF.md
# Light-Load Burst Mode Controller

This block sits beside the main switching logic of a flyback power controller and handles operation at very light load. It watches digital flags from external feedback and current-sense comparators, together with the current valley-skip setting of the normal-mode controller. When the load has clearly been light for long enough, it takes over the gate request. The converter then switches in short packets, each paced by a fixed-frequency timer with a 50% duty ceiling, and pauses between packets.

Packets start and stop on a hysteresis band of the feedback level. A sharp rise in feedback, caused by a sudden load step, ends burst operation at once. On that exit the block sends a single-cycle pulse that returns the valley-skip counter to its minimum, so full power is available straight away. Every comparator flag passes through a two-stage synchronizer before it is used. A flag change made before clock edge k therefore acts on the state at edge k+2, and the state's outputs show after that edge.

Top module: `lightload_burst`

## Requirements
- R1: During and after an asynchronous active-low reset, burstActive, gateReq and valleyPreset are 0 and the block is in normal (non-burst) mode.
- R2: Burst mode is entered only when the below-entry feedback flag is 1 and valleyCount equals its maximum (all ones, 7 for a 3-bit count) on BLANK_CYC consecutive synchronized samples. burstActive rises three clock edges after the last of those conditions became true at the inputs plus BLANK_CYC-1 further edges. Any other valley value never leads to entry.
- R3: If either entry condition is missing on any synchronized sample, the blanking count restarts from zero.
- R4: In burst mode, packet switching starts when the above-on flag is seen and continues after that flag drops, until the below-off flag is seen. gateReq is 0 while not switching. The below-off flag does not by itself leave burst mode.
- R5: While switching, gateReq turns on once every PERIOD_CYC clock cycles. The first turn-on is one cycle after switching is enabled.
- R6: Each gate pulse lasts at most PERIOD_CYC/2 cycles, which is a 50% duty cap.
- R7: A synchronized burst current-limit flag ends the present gate pulse on the following edge. The next pulse still starts on the regular period boundary.
- R8: When the above-exit flag is seen in either burst sub-state, burst mode ends on that edge. This takes priority over the above-on flag, and gateReq is 0 from the following cycle.
- R9: valleyPreset is a single-cycle pulse in the first cycle after burst exit. It is never produced on entry.
- R10: Outside burst mode, gateReq stays 0 whatever the on, off and current-limit flags do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fbBelowEntry | input | 1 | Feedback is below the burst entry level |
| fbAboveOn | input | 1 | Feedback is above the packet start level |
| fbBelowOff | input | 1 | Feedback is below the packet stop level |
| fbAboveExit | input | 1 | Feedback is above the burst exit level |
| csAtBurstLimit | input | 1 | Sensed current has reached the reduced burst limit |
| valleyCount | input | VALLEY_W | Present valley-skip setting of the normal-mode controller |
| burstActive | output | 1 | Block is in burst mode |
| gateReq | output | 1 | Gate request during burst packets |
| valleyPreset | output | 1 | One-cycle pulse that sets the valley counter to 1 |

## Verification
A blanking counter that fails to restart moves the rising edge of burstActive earlier than the expected cycle. A wrong phase counter or duty compare shifts the gateReq edges within the first packet period, at most sixteen cycles after switching starts. A state register stuck in a burst sub-state shows up as gateReq pulses or a missing valleyPreset within five cycles of the exit flag. A lost current-limit path keeps gateReq high up to four cycles longer than expected in the tripped period.

// File: rtl/lightload_burst_pkg.sv
package lightload_burst_pkg;

  // positions of the comparator flags inside the synchronizer vector
  localparam int FLAG_COUNT     = 5;
  localparam int FL_BELOW_ENTRY = 0;
  localparam int FL_ABOVE_ON    = 1;
  localparam int FL_BELOW_OFF   = 2;
  localparam int FL_ABOVE_EXIT  = 3;
  localparam int FL_CS_TRIP     = 4;

  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_IDLE   = 2'd1,
    ST_SWITCH = 2'd2
  } burst_state_t;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic blankRun;   // entry conditions present, advance blanking count
    logic pwmRun;     // packet switching enabled
  } burst_strobe_t;

endpackage

// File: rtl/burst_flag_sync.sv
module burst_flag_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], rawIn[b]};
    end
    assign syncOut[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/burst_timer_path.sv
module burst_timer_path
  import lightload_burst_pkg::*;
#(
  parameter int BLANK_CYC  = 1200000,
  parameter int PERIOD_CYC = 961
) (
  input  logic          clk,
  input  logic          rstN,
  input  burst_strobe_t strobe,
  input  logic          csTrip,
  output logic          blankDone,
  output logic          gateReq
);

  localparam int BW       = $clog2(BLANK_CYC + 1);
  localparam int PW       = $clog2(PERIOD_CYC);
  localparam int HALF_CYC = PERIOD_CYC / 2;
  localparam logic [BW-1:0] BLANK_LAST  = BW'(BLANK_CYC - 1);
  localparam logic [PW-1:0] PERIOD_LAST = PW'(PERIOD_CYC - 1);
  localparam logic [PW-1:0] HALF_P      = PW'(HALF_CYC);

  logic [BW-1:0] blankCnt;
  logic [PW-1:0] phase;

  // blanking window: consecutive cycles with all entry conditions present
  assign blankDone = strobe.blankRun && (blankCnt == BLANK_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 blankCnt <= '0;
    else if (!strobe.blankRun) blankCnt <= '0;
    else if (blankDone)        blankCnt <= '0;
    else                       blankCnt <= blankCnt + 1'b1;
  end

  // fixed-frequency packet timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 phase <= '0;
    else if (!strobe.pwmRun)   phase <= '0;
    else if (phase == PERIOD_LAST) phase <= '0;
    else                       phase <= phase + 1'b1;
  end

  // gate: on at period start, off at current limit or half period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         gateReq <= 1'b0;
    else if (!strobe.pwmRun)           gateReq <= 1'b0;
    else if (phase == '0)              gateReq <= 1'b1;
    else if (csTrip || phase >= HALF_P) gateReq <= 1'b0;
  end

  // run length of the gate pulse, for the duty-cap check
  logic [PW:0] highRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        highRun <= '0;
    else if (gateReq) highRun <= highRun + 1'b1;
    else              highRun <= '0;
  end

  assert_duty_cap_R6: assert property (@(posedge clk) disable iff (!rstN)
    gateReq |-> (highRun < (PW+1)'(HALF_CYC)));

  assert_turn_on_phase_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateReq) |-> (phase == PW'(1)));

  assert_trip_ends_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pwmRun && csTrip && phase != '0) |=> !gateReq);

endmodule

// File: rtl/burst_mode_ctrl.sv
module burst_mode_ctrl
  import lightload_burst_pkg::*;
#(
  parameter int VALLEY_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                belowEntry,
  input  logic                aboveOn,
  input  logic                belowOff,
  input  logic                aboveExit,
  input  logic [VALLEY_W-1:0] valleyCount,
  input  logic                blankDone,
  output burst_strobe_t       strobe,
  output logic                burstActive,
  output logic                valleyPreset
);

  localparam logic [VALLEY_W-1:0] VALLEY_MAX = '1;

  burst_state_t state, stateNext;
  logic entryOk;

  assign entryOk = belowEntry && (valleyCount == VALLEY_MAX);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_NORMAL: if (entryOk && blankDone) stateNext = ST_IDLE;
      ST_IDLE: begin
        if (aboveExit)    stateNext = ST_NORMAL;
        else if (aboveOn) stateNext = ST_SWITCH;
      end
      ST_SWITCH: begin
        if (aboveExit)     stateNext = ST_NORMAL;
        else if (belowOff) stateNext = ST_IDLE;
      end
      default: stateNext = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_NORMAL;
      valleyPreset <= 1'b0;
    end else begin
      state        <= stateNext;
      valleyPreset <= (state != ST_NORMAL) && aboveExit;
    end
  end

  assign burstActive     = (state != ST_NORMAL);
  assign strobe.blankRun = (state == ST_NORMAL) && entryOk;
  assign strobe.pwmRun   = (state == ST_SWITCH);

  assert_entry_gated_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(burstActive) |-> ($past(entryOk) && $past(blankDone)));

  assert_exit_now_R8: assert property (@(posedge clk) disable iff (!rstN)
    (burstActive && aboveExit) |=> (!burstActive && valleyPreset));

  assert_preset_on_exit_R9: assert property (@(posedge clk) disable iff (!rstN)
    valleyPreset |-> (!burstActive && $past(burstActive)));

  assert_preset_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    valleyPreset |=> !valleyPreset);

endmodule

// File: rtl/lightload_burst.sv
module lightload_burst
  import lightload_burst_pkg::*;
#(
  parameter int CLK_HZ       = 50000000,
  parameter int BLANK_US     = 24000,
  parameter int BURST_PWM_HZ = 52000,
  parameter int VALLEY_W     = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fbBelowEntry,
  input  logic                fbAboveOn,
  input  logic                fbBelowOff,
  input  logic                fbAboveExit,
  input  logic                csAtBurstLimit,
  input  logic [VALLEY_W-1:0] valleyCount,
  output logic                burstActive,
  output logic                gateReq,
  output logic                valleyPreset
);

  localparam int BLANK_CYC  = (CLK_HZ / 1000000) * BLANK_US;
  localparam int PERIOD_CYC = CLK_HZ / BURST_PWM_HZ;

  logic [FLAG_COUNT-1:0] rawFlags, syncFlags;
  burst_strobe_t strobe;
  logic blankDone;

  always_comb begin
    rawFlags                 = '0;
    rawFlags[FL_BELOW_ENTRY] = fbBelowEntry;
    rawFlags[FL_ABOVE_ON]    = fbAboveOn;
    rawFlags[FL_BELOW_OFF]   = fbBelowOff;
    rawFlags[FL_ABOVE_EXIT]  = fbAboveExit;
    rawFlags[FL_CS_TRIP]     = csAtBurstLimit;
  end

  burst_flag_sync #(.WIDTH(FLAG_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .rawIn(rawFlags), .syncOut(syncFlags));

  burst_mode_ctrl #(.VALLEY_W(VALLEY_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .belowEntry(syncFlags[FL_BELOW_ENTRY]),
    .aboveOn(syncFlags[FL_ABOVE_ON]),
    .belowOff(syncFlags[FL_BELOW_OFF]),
    .aboveExit(syncFlags[FL_ABOVE_EXIT]),
    .valleyCount(valleyCount),
    .blankDone(blankDone),
    .strobe(strobe),
    .burstActive(burstActive),
    .valleyPreset(valleyPreset));

  burst_timer_path #(.BLANK_CYC(BLANK_CYC), .PERIOD_CYC(PERIOD_CYC)) u_path (
    .clk(clk), .rstN(rstN),
    .strobe(strobe),
    .csTrip(syncFlags[FL_CS_TRIP]),
    .blankDone(blankDone),
    .gateReq(gateReq));

  assert_gate_quiet_outside_R10: assert property (@(posedge clk) disable iff (!rstN)
    !burstActive |=> !gateReq);

endmodule

// File: tb/lightload_burst_bench.sv
module lightload_burst_bench;

  localparam int B = 30;   // blanking cycles: 1 MHz * 30 us
  localparam int P = 16;   // packet period: 1 MHz / 62.5 kHz

  logic clk = 1'b0;
  always #4 clk = ~clk;    // 125 MHz

  logic rstN, fbBelowEntry, fbAboveOn, fbBelowOff, fbAboveExit, csAtBurstLimit;
  logic [2:0] valleyCount;
  logic burstActive, gateReq, valleyPreset;

  lightload_burst #(.CLK_HZ(1000000), .BLANK_US(B), .BURST_PWM_HZ(62500),
                    .VALLEY_W(3), .SYNC_STAGES(2)) u_lightload_burst (
    .clk(clk), .rstN(rstN),
    .fbBelowEntry(fbBelowEntry), .fbAboveOn(fbAboveOn), .fbBelowOff(fbBelowOff),
    .fbAboveExit(fbAboveExit), .csAtBurstLimit(csAtBurstLimit),
    .valleyCount(valleyCount),
    .burstActive(burstActive), .gateReq(gateReq), .valleyPreset(valleyPreset));

  typedef struct {
    int    at;
    int    sig;   // 0 burstActive, 1 gateReq, 2 valleyPreset
    logic  val;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0, total = 0, bad = 0;
  bit finished = 0;
  logic act;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic pick(int s);
    case (s)
      0:       return burstActive;
      1:       return gateReq;
      default: return valleyPreset;
    endcase
  endfunction

  task automatic expectAt(int dt, int sig, logic val, string tag);
    exp_t e;
    e.at = cyc + dt; e.sig = sig; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare scoreboard items whose cycle has come
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at <= cyc) begin
        total++;
        act = pick(q[i].sig);
        if (q[i].at < cyc || act !== q[i].val) begin
          bad++;
          $display("FAIL %s at cycle %0d: actual=%b expected=%b", q[i].tag, cyc, act, q[i].val);
        end
        q.delete(i);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired at cycle %0d: actual=hung expected=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; fbBelowEntry = 0; fbAboveOn = 0; fbBelowOff = 0;
    fbAboveExit = 0; csAtBurstLimit = 0; valleyCount = 3'd1;
    step(3);
    rstN = 1'b1;
    expectAt(1, 0, 1'b0, "R1 burstActive after reset");
    expectAt(1, 1, 1'b0, "R1 gateReq after reset");
    expectAt(1, 2, 1'b0, "R1 valleyPreset after reset");
    step(3);

    // R2 / R10: valley not at max, feedback low; packet flags toggled in normal mode
    valleyCount = 3'd6; fbBelowEntry = 1; fbAboveOn = 1; csAtBurstLimit = 1;
    expectAt(B + 5,  0, 1'b0, "R2 no entry with valley 6");
    expectAt(10,     1, 1'b0, "R10 gate quiet in normal mode (on flag)");
    step(20);
    fbAboveOn = 0; fbBelowOff = 1;
    expectAt(10,     1, 1'b0, "R10 gate quiet in normal mode (off flag)");
    step(20);
    fbBelowEntry = 0; fbBelowOff = 0; csAtBurstLimit = 0; valleyCount = 3'd7;
    step(5);

    // R3 / R2: window broken for one cycle, then full window
    fbBelowEntry = 1;
    expectAt(2 + B, 0, 1'b0, "R3 blanking restarted after gap");
    step(20);
    fbBelowEntry = 0;
    step(1);
    fbBelowEntry = 1;
    expectAt(1 + B, 0, 1'b0, "R2 not yet in burst one cycle early");
    expectAt(2 + B, 0, 1'b1, "R2 burst entered after blanking");
    expectAt(2 + B, 2, 1'b0, "R9 no preset on entry");
    expectAt(3 + B, 1, 1'b0, "R4 gate low in burst before on flag");
    step(B + 4);
    fbBelowEntry = 0;
    step(2);

    // R4 / R5 / R6 / R7: start packets, hysteresis, current trip
    fbAboveOn = 1;
    expectAt(3,  1, 1'b0, "R5 gate still low when switching enabled");
    expectAt(4,  1, 1'b1, "R5 first turn-on");
    expectAt(11, 1, 1'b1, "R6 gate held to half period");
    expectAt(12, 1, 1'b0, "R6 gate off at half period");
    expectAt(19, 1, 1'b0, "R5 gate low end of period");
    expectAt(20, 1, 1'b1, "R5 second turn-on after one period");
    expectAt(23, 1, 1'b1, "R7 pulse before trip");
    expectAt(24, 1, 1'b0, "R7 current trip ends pulse");
    expectAt(36, 1, 1'b1, "R7 next period starts on schedule");
    expectAt(30, 0, 1'b1, "R4 burst held while switching");
    step(2);
    fbAboveOn = 0;
    step(19);
    csAtBurstLimit = 1;
    step(2);
    csAtBurstLimit = 0;
    step(17);

    // R4: below-off stops packets but stays in burst
    fbBelowOff = 1;
    expectAt(4,  1, 1'b0, "R4 packets stopped by off flag");
    expectAt(15, 1, 1'b0, "R4 no pulse after stop");
    expectAt(31, 1, 1'b0, "R4 no pulse after stop (later)");
    expectAt(31, 0, 1'b1, "R4 off flag does not exit burst");
    step(2);
    fbBelowOff = 0;
    step(38);

    // R4 re-enable, then R8 / R9 exit while switching
    fbAboveOn = 1;
    expectAt(4, 1, 1'b1, "R4 packets restart from idle");
    step(2);
    fbAboveOn = 0;
    step(8);
    fbAboveExit = 1;
    expectAt(2, 0, 1'b1, "R8 still in burst before sync");
    expectAt(3, 0, 1'b0, "R8 exit from switching");
    expectAt(2, 2, 1'b0, "R9 preset low before exit");
    expectAt(3, 2, 1'b1, "R9 preset pulse on exit");
    expectAt(4, 2, 1'b0, "R9 preset lasts one cycle");
    expectAt(4, 1, 1'b0, "R8 gate off after exit");
    expectAt(5, 1, 1'b0, "R8 gate stays off after exit");
    step(2);
    fbAboveExit = 0;
    step(10);

    // re-enter, then exit from idle with on flag present (R8 priority)
    fbBelowEntry = 1;
    expectAt(2 + B, 0, 1'b1, "R2 second entry");
    step(B + 5);
    fbBelowEntry = 0; fbAboveOn = 1; fbAboveExit = 1;
    expectAt(3, 0, 1'b0, "R8 exit wins over on flag");
    expectAt(3, 2, 1'b1, "R9 preset on exit from idle");
    expectAt(4, 1, 1'b0, "R8 no packet after exit");
    expectAt(6, 1, 1'b0, "R10 no packet in normal mode");
    step(2);
    fbAboveOn = 0; fbAboveExit = 0;
    step(10);

    for (int i = 0; i < q.size(); i++) begin
      total++; bad++;
      $display("FAIL %s: actual=unchecked expected=checked", q[i].tag);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule